// File: doc/BRIEF.md
# Microprogram Sequencer with Subroutine Register

This block produces the control-memory address for a microprogrammed control unit and holds the control store. A 7-bit address register points into a 128 x 20-bit writable store. The word at that address is presented combinationally as the current microinstruction. Its low fields choose the next address: sequential step, conditional jump, conditional call with a single saved return address, return, or a jump into a per-opcode routine table.

Datapath status arrives on dedicated inputs: the indirect bit, the accumulator sign, an accumulator-zero flag and the 4-bit opcode of the current machine instruction. The micro-operation fields are passed out undecoded, because downstream decoders use them.

Execution starts at the fetch routine at word 64. The lower 64 words hold one 4-word slot per opcode. The store is loaded through a synchronous write port, normally while reset is held.

Top module: `mseq_top`

## Requirements
- R1: While rst_ni is low, the address register reads 64 and the return register reads 0; both keep these values until the first rising clock edge after release.
- R2: uinst_o always equals the store word at address car_o. Word layout from bit 19 down to bit 0 is: three 3-bit micro-operation fields, cond select [10:9], branch type [8:7], target address [6:0].
- R3: Cond select picks the tested bit: 00 constant 1, 01 ind_i, 10 sign_i, 11 zero_i.
- R4: Branch type 00 (jump): the next address is the target when the tested bit is 1, else car_o + 1.
- R5: Branch type 01 (call): when the tested bit is 1, the next address is the target and the return register takes car_o + 1. When it is 0, the address increments and the return register is unchanged. No other branch type alters the return register.
- R6: Branch type 10 (return): the next address is the return register's value, whatever the tested bit is.
- R7: Branch type 11 (map): the next address is {0, opcode_i[3:0], 00}, so opcode n enters at word 4n.
- R8: Incrementing wraps from 127 to 0, and a call taken at 127 saves 0.
- R9: Only one return address is kept: a second taken call overwrites the first.
- R10: A word written through the load port while running is stored on the rising edge and appears on uinst_o once car_o addresses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control store write strobe |
| wr_addr_i | input | 7 | Control store write address |
| wr_data_i | input | 20 | Control store write data |
| ind_i | input | 1 | Indirect bit of the data register |
| sign_i | input | 1 | Accumulator sign bit |
| zero_i | input | 1 | Accumulator equals zero |
| opcode_i | input | 4 | Opcode field of the data register |
| car_o | output | 7 | Current control address |
| sbr_o | output | 7 | Saved return address |
| uinst_o | output | 20 | Current microinstruction |

## Verification
The hardest situations to reach from the ports are chains of calls and returns, such as a second call before the return or a call taken at word 127 that saves a wrapped address. A store write that lands on exactly the word the sequencer is about to fetch is equally hard to reach. A directed program is loaded under reset to walk through nested calls, a return with a false condition, a map, and a wrap. A write is then aimed at the next fetched word. After that, a seeded random store and random status drive thousands of steps, with occasional writes, against a bench reference model.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int unsigned CS_AW = 7;
  localparam int unsigned CS_DW = 20;
  localparam int unsigned OP_W  = 4;

  typedef enum logic [1:0] {
    BR_JMP  = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } br_e;

  typedef enum logic [1:0] {
    CD_ONE  = 2'b00,
    CD_IND  = 2'b01,
    CD_SIGN = 2'b10,
    CD_ZERO = 2'b11
  } cd_e;

  typedef struct packed {
    logic [2:0]       f1;
    logic [2:0]       f2;
    logic [2:0]       f3;
    cd_e              cd;
    br_e              br;
    logic [CS_AW-1:0] ad;
  } uinst_t;
endpackage

// File: rtl/mseq_store.sv
module mseq_store #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 20,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/mseq_next.sv
module mseq_next
  import mseq_pkg::*;
#(
  parameter int unsigned AW = 7,
  parameter int unsigned OW = 4
) (
  input  logic [AW-1:0] car_i,
  input  logic [AW-1:0] sbr_i,
  input  cd_e           cd_i,
  input  br_e           br_i,
  input  logic [AW-1:0] ad_i,
  input  logic          ind_i,
  input  logic          sign_i,
  input  logic          zero_i,
  input  logic [OW-1:0] opcode_i,
  output logic          cond_o,
  output logic [AW-1:0] car_nxt_o,
  output logic [AW-1:0] sbr_nxt_o
);
  localparam int unsigned SLOT_W = 2;
  localparam int unsigned PAD_W  = AW - OW - SLOT_W;

  logic [AW-1:0] car_inc;
  logic [AW-1:0] map_addr;

  assign car_inc = car_i + AW'(1);

  generate
    if (PAD_W > 0) begin : g_pad
      assign map_addr = {{PAD_W{1'b0}}, opcode_i, {SLOT_W{1'b0}}};
    end else begin : g_nopad
      assign map_addr = {opcode_i, {SLOT_W{1'b0}}};
    end
  endgenerate

  always_comb begin
    unique case (cd_i)
      CD_ONE:  cond_o = 1'b1;
      CD_IND:  cond_o = ind_i;
      CD_SIGN: cond_o = sign_i;
      default: cond_o = zero_i;
    endcase
  end

  always_comb begin
    car_nxt_o = car_inc;
    sbr_nxt_o = sbr_i;
    unique case (br_i)
      BR_JMP:  if (cond_o) car_nxt_o = ad_i;
      BR_CALL: if (cond_o) begin
                 car_nxt_o = ad_i;
                 sbr_nxt_o = car_inc;
               end
      BR_RET:  car_nxt_o = sbr_i;
      default: car_nxt_o = map_addr;
    endcase
  end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int unsigned            FETCH_ADDR = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CS_AW-1:0] wr_addr_i,
  input  logic [CS_DW-1:0] wr_data_i,
  input  logic             ind_i,
  input  logic             sign_i,
  input  logic             zero_i,
  input  logic [OP_W-1:0]  opcode_i,
  output logic [CS_AW-1:0] car_o,
  output logic [CS_AW-1:0] sbr_o,
  output logic [CS_DW-1:0] uinst_o
);
  logic [CS_AW-1:0] car_q, sbr_q, car_nxt, sbr_nxt;
  logic [CS_DW-1:0] rd_word;
  uinst_t           ui;
  logic             cond_hit;

  mseq_store #(.AW(CS_AW), .DW(CS_DW)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (car_q),
    .rd_data_o (rd_word)
  );

  assign ui = uinst_t'(rd_word);

  mseq_next #(.AW(CS_AW), .OW(OP_W)) u_next (
    .car_i     (car_q),
    .sbr_i     (sbr_q),
    .cd_i      (ui.cd),
    .br_i      (ui.br),
    .ad_i      (ui.ad),
    .ind_i     (ind_i),
    .sign_i    (sign_i),
    .zero_i    (zero_i),
    .opcode_i  (opcode_i),
    .cond_o    (cond_hit),
    .car_nxt_o (car_nxt),
    .sbr_nxt_o (sbr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_q <= CS_AW'(FETCH_ADDR);
      sbr_q <= '0;
    end else begin
      car_q <= car_nxt;
      sbr_q <= sbr_nxt;
    end
  end

  assign car_o   = car_q;
  assign sbr_o   = sbr_q;
  assign uinst_o = rd_word;
endmodule

// File: rtl/mseq_checker.sv
module mseq_checker
  import mseq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OP_W-1:0]  opcode_i,
  input logic [CS_AW-1:0] car_o,
  input logic [CS_AW-1:0] sbr_o,
  input logic [CS_DW-1:0] uinst_o,
  input logic             cond_hit
);
  br_e              br;
  logic [CS_AW-1:0] ad;
  assign br = br_e'(uinst_o[8:7]);
  assign ad = uinst_o[6:0];

  p_reset_val_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (car_o == 7'd64 && sbr_o == 7'd0));

  p_jmp_taken_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br == BR_JMP && cond_hit) |=> car_o == $past(ad));

  p_step_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((br == BR_JMP || br == BR_CALL) && !cond_hit) |=> car_o == 7'($past(car_o) + 7'd1));

  p_call_save_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br == BR_CALL && cond_hit) |=> (car_o == $past(ad) && sbr_o == 7'($past(car_o) + 7'd1)));

  p_sbr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(br == BR_CALL && cond_hit) |=> $stable(sbr_o));

  p_ret_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br == BR_RET) |=> car_o == $past(sbr_o));

  p_map_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br == BR_MAP) |=> car_o == {1'b0, $past(opcode_i), 2'b00});
endmodule

bind mseq_top mseq_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .opcode_i (opcode_i),
  .car_o    (car_o),
  .sbr_o    (sbr_o),
  .uinst_o  (uinst_o),
  .cond_hit (cond_hit)
);

// File: tb/mseq_top_test.sv
module mseq_top_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [19:0] wr_data = '0;
  logic        ind = 1'b0, sign = 1'b0, zero = 1'b0;
  logic [3:0]  opcode = '0;
  logic [6:0]  car, sbr;
  logic [19:0] uinst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [19:0] m_mem [128];
  logic [6:0]  m_car, m_sbr;

  always #5 clk = ~clk;

  mseq_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ind_i(ind), .sign_i(sign), .zero_i(zero),
    .opcode_i(opcode), .car_o(car), .sbr_o(sbr), .uinst_o(uinst)
  );

  function automatic logic [19:0] mk(input logic [1:0] cd, input logic [1:0] br,
                                     input logic [6:0] ad);
    return {9'b101_011_110, cd, br, ad};
  endfunction

  // R3 condition selection
  function automatic logic tested(input logic [1:0] cd);
    case (cd)
      2'b00:   return 1'b1;
      2'b01:   return ind;
      2'b10:   return sign;
      default: return zero;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] br);
    case (br)
      2'b00:   return "R3 R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (car=%0d)", tag, got, exp, car);
    end
  endtask

  // one cycle: drive status (and optional write), check, advance model
  task automatic step(input logic i, input logic s, input logic z, input logic [3:0] op,
                      input logic we, input logic [6:0] wa, input logic [19:0] wd);
    logic [19:0] w;
    logic        c;
    logic [6:0]  inc;
    string       t;
    ind = i; sign = s; zero = z; opcode = op;
    wr_en = we; wr_addr = wa; wr_data = wd;
    #1;
    w = m_mem[m_car];
    check("R2", uinst, w);
    c   = tested(w[10:9]);
    inc = m_car + 7'd1;
    t   = tag_of(w[8:7]);
    case (w[8:7])
      2'b00: m_car = c ? w[6:0] : inc;
      2'b01: begin
        if (c) begin m_sbr = inc; m_car = w[6:0]; end
        else m_car = inc;
      end
      2'b10: m_car = m_sbr;
      default: m_car = {1'b0, op, 2'b00};
    endcase
    if (we) m_mem[wa] = wd;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check({t, " car"}, car, m_car);
    check("R5 sbr", sbr, m_sbr);
  endtask

  task automatic load(input logic [6:0] a, input logic [19:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    m_mem[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    for (int a = 0; a < 128; a++) load(7'(a), mk(2'b00, 2'b00, 7'd64));
    load(7'd64,  mk(2'b00, 2'b01, 7'd10));   // call U 10
    load(7'd10,  mk(2'b10, 2'b00, 7'd20));   // jmp S 20
    load(7'd11,  mk(2'b01, 2'b10, 7'd0));    // ret, cond I
    load(7'd65,  mk(2'b00, 2'b11, 7'd0));    // map
    load(7'd44,  mk(2'b00, 2'b00, 7'd127));  // jmp U 127
    load(7'd127, mk(2'b01, 2'b00, 7'd3));    // jmp I 3
    load(7'd0,   mk(2'b00, 2'b01, 7'd5));    // call U 5
    load(7'd5,   mk(2'b11, 2'b01, 7'd9));    // call Z 9
    load(7'd9,   mk(2'b01, 2'b10, 7'd0));    // ret, cond I
    load(7'd6,   mk(2'b10, 2'b01, 7'd100));  // call S 100
    // R1 reset values while held
    check("R1 car", car, 7'd64);
    check("R1 sbr", sbr, 7'd0);
    rst_ni = 1'b1;
    m_car = 7'd64; m_sbr = 7'd0;
    #1;
    check("R1 car after release", car, 7'd64);
    step(0, 0, 0, 4'h0, 0, 0, 0);              // call taken
    check("R5 call target", car, 7'd10);
    step(0, 0, 0, 4'h0, 0, 0, 0);              // sign 0: fall through
    check("R3 R4 not taken", car, 7'd11);
    step(1, 0, 0, 4'h0, 0, 0, 0);              // return, cond true anyway
    check("R6 return", car, 7'd65);
    step(0, 0, 0, 4'hB, 0, 0, 0);              // map opcode 11
    check("R7 map", car, 7'd44);
    step(0, 0, 0, 4'h0, 0, 0, 0);
    step(0, 0, 0, 4'h0, 0, 0, 0);              // 127 -> 0
    check("R8 wrap", car, 7'd0);
    step(0, 0, 0, 4'h0, 0, 0, 0);
    check("R5 first call", sbr, 7'd1);
    step(0, 0, 1, 4'h0, 0, 0, 0);
    check("R9 overwrite", sbr, 7'd6);
    step(0, 0, 0, 4'h0, 0, 0, 0);
    check("R6 return cond false", car, 7'd6);
    step(0, 0, 0, 4'h0, 1, 7'd7, mk(2'b00, 2'b00, 7'd64)); // write next word
    check("R10 new word", uinst, mk(2'b00, 2'b00, 7'd64));
    check("R5 untaken call keeps sbr", sbr, 7'd6);
    step(0, 0, 0, 4'h0, 0, 0, 0);
    check("R10 new word used", car, 7'd64);
    // random store and status
    rst_ni = 1'b0;
    #1;
    check("R1 car re-reset", car, 7'd64);
    for (int a = 0; a < 128; a++) load(7'(a), 20'($urandom));
    rst_ni = 1'b1;
    m_car = 7'd64; m_sbr = 7'd0;
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], r[2], r[6:3], (r[10:7] == 4'd0), 7'($urandom), 20'($urandom));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule